// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 16-bit successive-approximation search. It drives a trial code to an external digital-to-analog converter and reads a single-bit comparator that reports whether the analog input is at or above that trial level. It decides the bits one at a time, starting with the most significant. Each bit takes two clocks. In the first clock the trial bit is presented. At the end of the second clock the comparator is sampled and the bit is kept or cleared.

A conversion starts on a falling edge of the active-low convert strobe while the active-low select is low. A busy flag stays high for the whole search. A convert request that arrives during a search is ignored. If the strobe is still low when a search finishes, the next search follows with no idle cycle. Each decided bit is also sent out on a serial line, with a strobe that falls one clock after the bit appears. At the end of a search the word is presented for one cycle with a valid pulse, ready for an output latch.

Top module: `sar_seq`

## Requirements
- R1: With `cs_n` low, a high-to-low transition of `wr_n` seen at a clock edge starts a conversion, and `busy` is high after that same edge. `trial_code` is then 16'h8000.
- R2: `busy` stays high for exactly 33 cycles after the starting edge and goes low on the 34th, unless R4 applies.
- R3: A falling edge of `wr_n` while `busy` is high has no effect on the timing or the result of the conversion in progress.
- R4: If `cs_n` and `wr_n` are both low at the edge where the conversion would end, a new conversion begins at that edge and `busy` stays high.
- R5: Bits are decided from bit 15 down to bit 0. For each bit, the trial bit is set, and one clock later it is kept if `cmp_ge` is 1 and cleared if it is 0. With an ideal comparator (`cmp_ge` = input >= `trial_code`), the result equals the input code.
- R6: Each conversion produces exactly 16 falling edges on `ser_strobe_n`. The `ser_data` values present at those edges, taken in order, form the result with the MSB first.
- R7: `ser_data` holds the same value for at least one clock before each falling edge of `ser_strobe_n`. The strobe stays low for one cycle.
- R8: `result_valid` is high for exactly one cycle, 32 cycles after the starting edge, and carries the final word on `result`. `busy` is still high in that cycle.
- R9: An active-low reset clears `busy`, `trial_code`, `result_valid` and `ser_data`, and leaves `ser_strobe_n` high. This also applies in the middle of a conversion.
- R10: With `cs_n` high, `wr_n` edges start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low convert strobe |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the trial level |
| trial_code | output | 16 | Code driven to the external DAC |
| busy | output | 1 | Conversion in progress |
| ser_data | output | 1 | Serial result bit, MSB first |
| ser_strobe_n | output | 1 | Serial strobe, falls once per bit |
| result_valid | output | 1 | One-cycle completion pulse |
| result | output | 16 | Converted word |

## Verification
The bench models an ideal comparator against a chosen input code. It covers the all-zero and all-one codes and codes on either side of mid-scale, because a design that sets the next trial bit on the wrong cycle, or keeps a bit on the wrong comparator polarity, returns a shifted or inverted word at exactly these codes. It also sends a second falling edge on the convert strobe in the middle of a search; a design that restarts on it would move the valid pulse and corrupt the word. Holding the strobe low through completion checks that the second search starts without a gap, so a design that releases busy for a cycle would be caught. A reset in the middle of a search, and strobe edges with select high, check that no stale state or false start remains.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic         cmp_ge,
  output logic [W-1:0] trial_code,
  output logic         busy,
  output logic         ser_data,
  output logic         ser_strobe_n,
  output logic         result_valid,
  output logic [W-1:0] result
);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic          wr_q;
  logic          phase;
  logic          fin;
  logic [IW-1:0] idx;
  logic [W-1:0]  sar;

  wire fall  = wr_q & ~wr_n & ~cs_n;
  wire again = ~cs_n & ~wr_n;

  assign trial_code = sar;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q         <= 1'b0;
      busy         <= 1'b0;
      phase        <= 1'b0;
      fin          <= 1'b0;
      idx          <= '0;
      sar          <= '0;
      ser_data     <= 1'b0;
      ser_strobe_n <= 1'b1;
      result_valid <= 1'b0;
      result       <= '0;
    end else begin
      wr_q         <= wr_n;
      result_valid <= 1'b0;
      if (!busy) begin
        if (fall) begin
          busy  <= 1'b1;
          sar   <= TOP;
          idx   <= LAST;
          phase <= 1'b0;
        end
      end else if (fin) begin
        fin          <= 1'b0;
        ser_strobe_n <= 1'b1;
        if (again) begin
          sar   <= TOP;
          idx   <= LAST;
          phase <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end else if (!phase) begin
        sar[idx]     <= cmp_ge;
        ser_data     <= cmp_ge;
        ser_strobe_n <= 1'b1;
        phase        <= 1'b1;
      end else begin
        ser_strobe_n <= 1'b0;
        phase        <= 1'b0;
        if (idx == '0) begin
          fin          <= 1'b1;
          result_valid <= 1'b1;
          result       <= sar;
        end else begin
          idx             <= idx - 1'b1;
          sar[idx - 1'b1] <= 1'b1;
        end
      end
    end
  end

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(!cs_n && !wr_n) && trial_code == TOP));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R8
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> busy);

  // R7
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_strobe_n) |-> $stable(ser_data));

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_strobe_n |=> ser_strobe_n);

  // R6
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_strobe_n);
endmodule

// File: tb/sar_seq_tb_top.sv
`timescale 1ns/1ps
module sar_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] ain = '0;
  logic [15:0] trial_code;
  logic        busy, ser_data, ser_strobe_n, result_valid;
  logic [15:0] result;
  logic        cmp_ge;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  assign cmp_ge = (ain >= trial_code);

  sar_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .busy(busy), .ser_data(ser_data),
    .ser_strobe_n(ser_strobe_n), .result_valid(result_valid), .result(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    cs_n = 1'b1;
    wr_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // fresh=1: drive a start now; fresh=0: the conversion restarted at the edge before the current negedge
  task automatic do_conv(input logic [15:0] v, input bit fresh, input int raise_at,
                         input int glitch_at, input bit expect_restart);
    logic [15:0] sword = '0;
    int nstb = 0;
    int busy_bad = 0;
    int rv_bad = 0;
    logic ps = 1'b1;
    logic pd = 1'b0;
    int first;
    ain = v;
    if (fresh) begin
      cs_n = 1'b0;
      wr_n = 1'b0;
      first = 1;
    end else begin
      first = 2;
      ps = ser_strobe_n;
      pd = ser_data;
    end
    for (int i = first; i <= 34; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check("R1 busy after start", busy, 1);
        check("R1 first trial", trial_code, 16'h8000);
      end
      if (i <= 33 && busy !== 1'b1) busy_bad++;
      if (result_valid !== (i == 33)) rv_bad++;
      if (i == 33) check("R5 result value", result, v);
      if (ps === 1'b1 && ser_strobe_n === 1'b0) begin
        check("R7 data stable at strobe", ser_data, pd);
        sword = {sword[14:0], ser_data};
        nstb++;
      end
      ps = ser_strobe_n;
      pd = ser_data;
      if (i == raise_at) wr_n = 1'b1;
      if (i == glitch_at) wr_n = 1'b1;
      if (i == glitch_at + 1 && glitch_at > 0) wr_n = 1'b0;
    end
    check("R2 busy held 33 cycles", busy_bad, 0);
    check("R8 single valid pulse at cycle 32", rv_bad, 0);
    check("R2/R4 busy after end", busy, expect_restart);
    if (fresh) begin
      check("R6 strobe count", nstb, 16);
      check("R6 serial word", sword, v);
    end
  endtask

  task automatic t_reset();
    check("R9 reset busy", busy, 0);
    check("R9 reset trial", trial_code, 0);
    check("R9 reset valid", result_valid, 0);
    check("R9 reset strobe", ser_strobe_n, 1);
    check("R9 reset sdata", ser_data, 0);
  endtask

  task automatic t_values();
    logic [15:0] vals [5] = '{16'hA5C3, 16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
    foreach (vals[k]) begin
      do_conv(vals[k], 1'b1, 2, 0, 1'b0);
      idle(3);
    end
  endtask

  task automatic t_ignore();
    // R3: second falling edge at cycle 9 must not disturb anything
    do_conv(16'h3C5A, 1'b1, 20, 8, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check("R3 no extra start", busy, 0);
    end
    idle(3);
  endtask

  task automatic t_restart();
    // R4: wr_n held low through completion
    do_conv(16'h1234, 1'b1, 0, 0, 1'b1);
    do_conv(16'hEDCB, 1'b0, 3, 0, 1'b0);
    idle(3);
  endtask

  task automatic t_cs_high();
    cs_n = 1'b1;
    wr_n = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check("R10 no start when deselected", busy, 0);
      check("R10 strobe idle", ser_strobe_n, 1);
    end
    idle(3);
  endtask

  task automatic t_reset_mid();
    ain = 16'h5555;
    cs_n = 1'b0;
    wr_n = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 busy before reset", busy, 1);
    rst_n = 1'b0;
    cs_n = 1'b1;
    wr_n = 1'b1;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    check("R9 stays idle after reset", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_values();
    t_ignore();
    t_restart();
    t_cs_high();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule